// File: doc/BRIEF.md
# Interrupt-to-DMA Request Router

This block sits between a set of internal interrupt sources and a multi-channel DMA transfer engine. Each DMA channel picks one source through a small select field. When a selected source raises its flag and the channel is enabled, the channel latches a pending request. A fixed-priority arbiter then issues one activation strobe at a time to the engine. The interrupt-controller's priority settings play no part in this choice. The block holds off further activations until the engine reports that the running channel's transfer is done.

At each completion the block decides whether to pulse a clear back to the source flag. That decision depends on three things: whether the source is dedicated to DMA, whether the source only clears when its data register is touched, and whether the flag is still set. The block also drives a forwarded interrupt line per source toward the CPU / transfer-coprocessor path. A request is withheld from that path only when the source is dedicated to DMA and at least one enabled channel claims it. One source may feed several channels. Each of those channels latches its own request and they are served lowest index first, but the flag is cleared only once.

All edges are plain control strobes and levels. No valid/ready pairs are used because no data flows through the block. The engine's completion strobe stands in for back-pressure: nothing new is activated while a transfer is outstanding.

Top module: `irq_dma_router`

## Requirements
- R1: After reset, `ch_act` and `src_clr` are all zero.
- R2: A rising edge of `src_flag[s]`, sampled at a clock edge while channel c is enabled and its 3-bit select field `ch_sel[3c+2:3c]` equals s, latches a pending request. The one-cycle strobe `ch_act[c]` follows one clock edge later, provided no transfer is running.
- R3: Channel 0 has the highest priority and channel 3 the lowest. At most one `ch_act` bit is set in any cycle. No new activation is issued between an activation and the `xfer_done` strobe of the activated channel.
- R4: When one source is selected by several enabled channels, every one of them activates once, in index order.
- R5: A channel whose enable `ch_en[c]` is 0 latches nothing and is never activated. A pending request is discarded when the channel's enable drops to 0 before its activation.
- R6: `irq_fwd[s]` is 1 exactly when `src_flag[s]` is 1 and either `src_dma_own[s]` is 0 or no enabled channel selects s. With `src_dma_own[s]` = 0, the request reaches both the DMA side and `irq_fwd` in the same cycle.
- R7: For a source with `src_dma_own` = 1 and `src_reg_clr` = 0, the running channel's `xfer_done` produces a one-cycle `src_clr[s]` pulse in the cycle after the edge where `xfer_done` was sampled.
- R8: For a source with `src_reg_clr` = 1, the clear pulse of R7 is given only when `xfer_reg_hit` is 1 together with `xfer_done`.
- R9: A source with `src_dma_own` = 0 never receives a `src_clr` pulse.
- R10: An `xfer_done` bit for a channel other than the running one is ignored. It produces no clear and does not end the running transfer.
- R11: No clear pulse is given if `src_flag[s]` is already 0 at completion. When several channels serve one event, the source therefore sees a single clear.
- R12: `src_clr` and `ch_act` are never both non-zero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_flag | input | 8 | Interrupt source flags, level |
| src_dma_own | input | 8 | Per source: 1 = dedicated to DMA |
| src_reg_clr | input | 8 | Per source: flag clears only if the transfer hit its data register |
| ch_en | input | 4 | Per-channel transfer enable |
| ch_sel | input | 12 | Per-channel 3-bit source select, channel c at bits 3c+2:3c |
| xfer_done | input | 4 | Per-channel transfer-complete strobe from the engine |
| xfer_reg_hit | input | 1 | Completing transfer accessed the source's data register |
| ch_act | output | 4 | Per-channel one-cycle activation strobe |
| src_clr | output | 8 | Per-source one-cycle flag-clear pulse |
| irq_fwd | output | 8 | Per-source request forwarded to the CPU / coprocessor path |

## Verification
The routing is driven in several ways. A single source feeds three channels, which separates per-channel latching from a shared request and shows the single clear. Two different sources rise in the same cycle, which exercises priority between sources rather than between channels. A source marked clear-on-access completes once with and once without the register hit, and a non-dedicated source completes with a hit. Together these tell the three clear policies apart. Completions on the wrong channel and enables dropped while a request is pending separate real completion tracking from any-strobe handling, and genuine discard from late service.

// File: rtl/irq_dma_router_pkg.sv
package irq_dma_router_pkg;
  typedef enum logic {
    RT_IDLE = 1'b0,
    RT_BUSY = 1'b1
  } rt_state_e;
endpackage

// File: rtl/rdr_pending.sv
module rdr_pending #(
  parameter int NCH  = 4,
  parameter int NSRC = 8,
  parameter int SW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_flag,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH*SW-1:0] ch_sel,
  input  logic [NCH-1:0]    taken,
  output logic [NCH-1:0]    pend
);
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] rise;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= src_flag;
  end

  assign rise = src_flag & ~flag_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] sel;
    assign sel = ch_sel[c*SW +: SW];
    always_ff @(posedge clk) begin
      if (!rst_n)          pend[c] <= 1'b0;
      else if (!ch_en[c])  pend[c] <= 1'b0;
      else if (rise[sel])  pend[c] <= 1'b1;
      else if (taken[c])   pend[c] <= 1'b0;
    end
  end
endmodule

// File: rtl/rdr_arbiter.sv
module rdr_arbiter #(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt,
  output logic [CW-1:0]  gnt_idx
);
  always_comb begin
    logic seen;
    seen    = 1'b0;
    gnt     = '0;
    gnt_idx = '0;
    for (int c = 0; c < NCH; c++) begin
      if (req[c] && !seen) begin
        gnt[c]  = 1'b1;
        gnt_idx = CW'(c);
      end
      seen = seen | req[c];
    end
  end
endmodule

// File: rtl/rdr_clear_ctl.sv
module rdr_clear_ctl #(
  parameter int NSRC = 8,
  parameter int SW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done_ev,
  input  logic [SW-1:0]   cur_src,
  input  logic            reg_hit,
  input  logic [NSRC-1:0] src_flag,
  input  logic [NSRC-1:0] dma_own,
  input  logic [NSRC-1:0] reg_clr,
  output logic [NSRC-1:0] clr
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic fire;
    assign fire = done_ev && (cur_src == SW'(s)) && src_flag[s] && dma_own[s]
                  && (!reg_clr[s] || reg_hit);
    always_ff @(posedge clk) begin
      if (!rst_n) clr[s] <= 1'b0;
      else        clr[s] <= fire;
    end
  end
endmodule

// File: rtl/rdr_fwd.sv
module rdr_fwd #(
  parameter int NCH  = 4,
  parameter int NSRC = 8,
  parameter int SW   = 3
) (
  input  logic [NSRC-1:0]   src_flag,
  input  logic [NSRC-1:0]   dma_own,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH*SW-1:0] ch_sel,
  output logic [NSRC-1:0]   fwd
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [NCH-1:0] hit;
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign hit[c] = ch_en[c] && (ch_sel[c*SW +: SW] == SW'(s));
    end
    assign fwd[s] = src_flag[s] && !(dma_own[s] && (|hit));
  end
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router #(
  parameter int NCH  = 4,
  parameter int NSRC = 8,
  localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_flag,
  input  logic [NSRC-1:0]   src_dma_own,
  input  logic [NSRC-1:0]   src_reg_clr,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH*SW-1:0] ch_sel,
  input  logic [NCH-1:0]    xfer_done,
  input  logic              xfer_reg_hit,
  output logic [NCH-1:0]    ch_act,
  output logic [NSRC-1:0]   src_clr,
  output logic [NSRC-1:0]   irq_fwd
);
  import irq_dma_router_pkg::*;

  rt_state_e       state;
  logic [CW-1:0]   cur_ch;
  logic [SW-1:0]   cur_src;
  logic [NCH-1:0]  pend;
  logic [NCH-1:0]  gnt;
  logic [CW-1:0]   gnt_idx;
  logic [NCH-1:0]  taken;
  logic [SW-1:0]   gnt_src;
  logic            done_ev;

  rdr_pending #(.NCH(NCH), .NSRC(NSRC), .SW(SW)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .ch_en(ch_en),
    .ch_sel(ch_sel), .taken(taken), .pend(pend)
  );

  rdr_arbiter #(.NCH(NCH)) u_arb (
    .req(pend & ch_en), .gnt(gnt), .gnt_idx(gnt_idx)
  );

  assign taken   = (state == RT_IDLE) ? gnt : '0;
  assign done_ev = (state == RT_BUSY) && xfer_done[cur_ch];

  always_comb begin
    gnt_src = '0;
    for (int c = 0; c < NCH; c++)
      if (gnt[c]) gnt_src = ch_sel[c*SW +: SW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RT_IDLE;
      cur_ch  <= '0;
      cur_src <= '0;
      ch_act  <= '0;
    end else begin
      ch_act <= taken;
      if (state == RT_IDLE && |taken) begin
        state   <= RT_BUSY;
        cur_ch  <= gnt_idx;
        cur_src <= gnt_src;
      end else if (done_ev) begin
        state <= RT_IDLE;
      end
    end
  end

  rdr_clear_ctl #(.NSRC(NSRC), .SW(SW)) u_clr (
    .clk(clk), .rst_n(rst_n), .done_ev(done_ev), .cur_src(cur_src),
    .reg_hit(xfer_reg_hit), .src_flag(src_flag), .dma_own(src_dma_own),
    .reg_clr(src_reg_clr), .clr(src_clr)
  );

  rdr_fwd #(.NCH(NCH), .NSRC(NSRC), .SW(SW)) u_fwd (
    .src_flag(src_flag), .dma_own(src_dma_own), .ch_en(ch_en),
    .ch_sel(ch_sel), .fwd(irq_fwd)
  );
endmodule

// File: rtl/irq_dma_router_chk.sv
module irq_dma_router_chk #(
  parameter int NCH  = 4,
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_flag,
  input logic [NSRC-1:0] src_dma_own,
  input logic [NSRC-1:0] src_reg_clr,
  input logic [NCH-1:0]  ch_en,
  input logic            xfer_reg_hit,
  input logic [NCH-1:0]  ch_act,
  input logic [NSRC-1:0] src_clr,
  input logic [NSRC-1:0] irq_fwd
);
  p_act_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_act));

  p_act_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_act) |=> (ch_act == '0));

  p_clr_act_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_clr) |-> (ch_act == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    p_act_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_act[c] |-> $past(ch_en[c]));
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    p_clr_own_r9: assert property (@(posedge clk) disable iff (!rst_n)
      src_clr[s] |-> $past(src_dma_own[s]));
    p_clr_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      src_clr[s] |-> $past(src_flag[s]));
    p_clr_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (src_clr[s] && $past(src_reg_clr[s])) |-> $past(xfer_reg_hit));
    p_fwd_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !src_flag[s] |-> !irq_fwd[s]);
    p_fwd_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_flag[s] && !src_dma_own[s]) |-> irq_fwd[s]);
  end
endmodule

bind irq_dma_router irq_dma_router_chk #(.NCH(NCH), .NSRC(NSRC)) chk_i (.*);

// File: tb/irq_dma_router_tb_top.sv
module irq_dma_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 4;
  localparam int NSRC = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NSRC-1:0]   src_flag, src_dma_own, src_reg_clr;
  logic [NCH-1:0]    ch_en, xfer_done;
  logic [NCH*3-1:0]  ch_sel;
  logic              xfer_reg_hit;
  logic [NCH-1:0]    ch_act;
  logic [NSRC-1:0]   src_clr, irq_fwd;

  int n_chk  = 0;
  int n_fail = 0;
  logic [NCH+NSRC-1:0] exp_q[$];
  string               tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dma_router #(.NCH(NCH), .NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_dma_own(src_dma_own),
    .src_reg_clr(src_reg_clr), .ch_en(ch_en), .ch_sel(ch_sel),
    .xfer_done(xfer_done), .xfer_reg_hit(xfer_reg_hit),
    .ch_act(ch_act), .src_clr(src_clr), .irq_fwd(irq_fwd)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic expect_ev(input logic [NCH-1:0] act, input logic [NSRC-1:0] clr, input string tag);
    exp_q.push_back({act, clr});
    tag_q.push_back(tag);
  endtask

  // monitor: every non-idle output cycle is matched against the scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && (ch_act != '0 || src_clr != '0)) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected event: got act=%b clr=%b expected none", ch_act, src_clr);
      end else begin
        logic [NCH+NSRC-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({ch_act, src_clr} !== e) begin
          n_fail++;
          $display("FAIL %s: got act=%b clr=%b expected act=%b clr=%b",
                   t, ch_act, src_clr, e[NCH+NSRC-1:NSRC], e[NSRC-1:0]);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done(input int c, input logic hit);
    xfer_done[c] = 1'b1;
    xfer_reg_hit = hit;
    @(negedge clk);
    xfer_done    = '0;
    xfer_reg_hit = 1'b0;
  endtask

  task automatic set_sel(input int c, input logic [2:0] s);
    ch_sel[c*3 +: 3] = s;
  endtask

  task automatic drained(input string tag);
    check(tag, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_flag = '0; src_dma_own = '0; src_reg_clr = '0;
    ch_en = '0; ch_sel = '0; xfer_done = '0; xfer_reg_hit = 1'b0;
    cyc(3);
    check("R1 act at reset", 32'(ch_act), 0);
    check("R1 clr at reset", 32'(src_clr), 0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 act after reset", 32'(ch_act), 0);

    src_dma_own = 8'b0010_0100;  // sources 2 and 5 dedicated
    src_reg_clr = 8'b0010_0000;  // source 5 clears on register access
    set_sel(0, 2); set_sel(1, 2); set_sel(2, 5); set_sel(3, 2);
    ch_en = 4'b1111;

    // R6: non-dedicated source forwards
    src_flag[3] = 1'b1; #1;
    check("R6 fwd non-dedicated", 32'(irq_fwd[3]), 1);
    cyc(1); src_flag[3] = 1'b0; cyc(1);

    // R2 R4 R7 R11: source 2 feeds channels 0, 1, 3
    expect_ev(4'b0001, 8'h00, "R2 R4 act ch0");
    expect_ev(4'b0000, 8'h04, "R7 clr src2");
    expect_ev(4'b0010, 8'h00, "R4 act ch1");
    expect_ev(4'b1000, 8'h00, "R4 act ch3");
    src_flag[2] = 1'b1; #1;
    check("R6 dedicated claimed not forwarded", 32'(irq_fwd[2]), 0);
    cyc(4); done(0, 1'b0);
    src_flag[2] = 1'b0;
    cyc(3); done(1, 1'b0);   // R11 flag already low: no clear
    cyc(3); done(3, 1'b0);
    cyc(4);
    drained("R4 R11 single clear");

    // R8: access-cleared source
    expect_ev(4'b0100, 8'h00, "R8 act ch2 no hit");
    src_flag[5] = 1'b1; cyc(4); done(2, 1'b0);
    cyc(2); src_flag[5] = 1'b0; cyc(2);
    drained("R8 no clear without hit");
    expect_ev(4'b0100, 8'h00, "R8 act ch2 hit");
    expect_ev(4'b0000, 8'h20, "R8 clr src5 hit");
    src_flag[5] = 1'b1; cyc(4); done(2, 1'b1);
    src_flag[5] = 1'b0; cyc(3);
    drained("R8 clear with hit");

    // R9 R6: non-dedicated source served by DMA, never cleared
    set_sel(2, 3);
    expect_ev(4'b0100, 8'h00, "R9 act ch2 src3");
    src_flag[3] = 1'b1; #1;
    check("R6 same-cycle forward", 32'(irq_fwd[3]), 1);
    cyc(4);
    check("R6 forward during transfer", 32'(irq_fwd[3]), 1);
    done(2, 1'b1);
    cyc(3); src_flag[3] = 1'b0; cyc(2);
    drained("R9 no clear when not dedicated");

    // R5: disabled channel and discarded pending
    ch_en = 4'b1001;
    expect_ev(4'b0001, 8'h00, "R5 act ch0 only");
    expect_ev(4'b0000, 8'h04, "R5 clr src2");
    src_flag[2] = 1'b1; cyc(4);
    ch_en = 4'b0001;         // drop ch3 while its request pends
    cyc(1); done(0, 1'b0);
    src_flag[2] = 1'b0; cyc(6);
    drained("R5 pending discarded");
    ch_en = 4'b0000;
    src_flag[2] = 1'b1; #1;
    check("R5 R6 unclaimed forwards", 32'(irq_fwd[2]), 1);
    cyc(4);
    ch_en = 4'b1111; cyc(4);
    src_flag[2] = 1'b0; cyc(2);
    drained("R5 no activation when disabled");

    // R10: completion on another channel ignored
    set_sel(2, 5);
    expect_ev(4'b0100, 8'h00, "R10 act ch2");
    expect_ev(4'b0000, 8'h20, "R10 clr only after own done");
    src_flag[5] = 1'b1; cyc(4);
    done(1, 1'b1);
    cyc(3);
    check("R10 still one event consumed", 32'(exp_q.size()), 1);
    done(2, 1'b1);
    src_flag[5] = 1'b0; cyc(3);
    drained("R10 wrong done ignored");

    // R3: two sources rise together, lower channel first
    src_dma_own = src_dma_own | 8'b1100_0000;
    set_sel(1, 6); set_sel(2, 7);
    expect_ev(4'b0010, 8'h00, "R3 act ch1 first");
    expect_ev(4'b0000, 8'h40, "R3 clr src6");
    expect_ev(4'b0100, 8'h00, "R3 act ch2 second");
    expect_ev(4'b0000, 8'h80, "R3 clr src7");
    src_flag[6] = 1'b1; src_flag[7] = 1'b1;
    cyc(4); done(1, 1'b0);
    src_flag[6] = 1'b0;
    cyc(3); done(2, 1'b0);
    src_flag[7] = 1'b0; cyc(3);
    drained("R3 priority order");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule